// File: doc/BRIEF.md
# Three-Pair Motor Drive PWM Generator

This block turns one shared time base into six gate-drive outputs, grouped as three half-bridge pairs. The time base runs in one of four modes: wrap-around up counting, a single up sweep that then parks, continuous up/down counting that reloads at the bottom, and up/down counting that reloads at both bottom and top. Each pair compares the count against its own duty value. A pair either drives its high and low sides as complements, with a programmable blanking gap after every switching edge, or drives both sides with the same waveform and no gap.

Period and duty values go through shadow registers. New settings reach the comparators only at a reload point, or at once while the time base is stopped, so a waveform never changes shape within a cycle. Every pin has its own polarity inversion and its own manual force. A one-cycle pulse flags each reload. A separate one-cycle pulse fires when the rising count matches a compare value, so A/D sampling can be placed at a fixed point in the waveform.

Top module: `mcpwm_core`

## Requirements
- R1: In mode 0 (`cfg_tbmode`=0) the count goes 0,1,…,P and then wraps to 0, so one cycle lasts P+1 clocks. A pair's raw drive is 1 while the count is strictly below its active duty value: duty 0 keeps it low and a duty above P keeps it high. Each pin shows the raw drive of the previous clock, so it lags the count by one cycle.
- R2: In modes 2 and 3 the count climbs from 0 to P and descends to 0, turning at each end, so one cycle lasts 2P clocks. P must be at least 1 in these modes.
- R3: In mode 1, after `cfg_run` rises the count sweeps 0..P once, returns to 0 and stays there while `cfg_run` remains high. Dropping `cfg_run` re-arms it.
- R4: A running time base adopts the duty and period inputs only at a reload point, and the new values take effect from the following count. While the time base is stopped the inputs are adopted every clock.
- R5: `tb_evt` pulses one clock after a reload point. In modes 0 and 1 a reload point is the cycle whose count equals P. In mode 2 it is the bottom turn, and mode 3 adds the top turn.
- R6: Pin 2i is the high side and pin 2i+1 the low side of pair i. When `cfg_indep[i]`=0 the low side carries the inverse of the raw drive, and after each raw edge both sides stay inactive for `cfg_dead` clocks. A pulse shorter than the gap is swallowed.
- R7: When `cfg_indep[i]`=1 both sides of pair i follow the raw drive, with no gap.
- R8: Each pin is XORed with its `cfg_pol` bit, so a 1 inverts that pin.
- R9: When `ovr_en[j]`=1, pin j shows `ovr_val[j]` XOR `cfg_pol[j]` one clock later, whatever the generator is doing.
- R10: `adc_trig` pulses one clock after a running cycle in which the count equals `cfg_trig` and the time base is not descending.
- R11: During reset every pin, `adc_trig` and `tb_evt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_run | input | 1 | Time base enable |
| cfg_tbmode | input | 2 | 0 wrap-up, 1 single sweep, 2 up/down, 3 up/down with double reload |
| cfg_period | input | CNT_W | Period P |
| cfg_duty | input | NUM_PAIRS*CNT_W | Duty value per pair, pair i in slice i |
| cfg_dead | input | DT_W | Blanking gap in clocks |
| cfg_indep | input | NUM_PAIRS | 1 = pair drives both sides from the same waveform |
| cfg_pol | input | 2*NUM_PAIRS | Per-pin inversion |
| ovr_en | input | 2*NUM_PAIRS | Per-pin manual force enable |
| ovr_val | input | 2*NUM_PAIRS | Per-pin forced level |
| cfg_trig | input | CNT_W | A/D trigger compare value |
| pwm_out | output | 2*NUM_PAIRS | Drive pins |
| adc_trig | output | 1 | A/D start pulse |
| tb_evt | output | 1 | Reload point pulse |

## Verification
Pins, `adc_trig` and `tb_evt` are all registered, so each reflects the count and settings of the clock before it. At each falling edge the bench checks them against the values its model computed for the previous count. The model takes the count straight from the cycle index as a closed-form expression. It decides each side's state from a history of raw drive bits, where a side is active only if its level has held for the last gap+1 samples. Shadow adoption is modelled as taking effect on the count after the predicted reload point. Overrides are checked one clock after they are applied.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

    typedef enum logic [1:0] {
        TB_WRAP     = 2'd0,
        TB_ONESHOT  = 2'd1,
        TB_UPDN     = 2'd2,
        TB_UPDN_DBL = 2'd3
    } tb_mode_e;

    localparam int SIDE_HI = 0;
    localparam int SIDE_LO = 1;

endpackage

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] trig_cmp,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_act,
    output logic             running,
    output logic             load,
    output logic             halted,
    output logic             evt,
    output logic             trig
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic             down;
        logic             halt;
        logic             evt;
        logic             trig;
    } tb_st_t;

    tb_st_t st_d, st_q;
    logic   run_ok;
    logic   upd;

    always_comb begin
        st_d      = st_q;
        st_d.evt  = 1'b0;
        st_d.trig = 1'b0;
        upd       = 1'b0;
        run_ok    = run && !st_q.halt;
        if (!run_ok) begin
            // idle: park at zero, track period, keep single-sweep latch until run drops
            st_d.cnt  = '0;
            st_d.down = 1'b0;
            st_d.halt = st_q.halt && run;
            st_d.per  = period;
        end else begin
            st_d.trig = !st_q.down && (st_q.cnt == trig_cmp);
            if (!mode[1]) begin
                if (st_q.cnt >= st_q.per) begin
                    st_d.cnt  = '0;
                    upd       = 1'b1;
                    st_d.halt = (mode == TB_ONESHOT);
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (!st_q.down) begin
                if (st_q.cnt >= st_q.per) begin
                    st_d.down = 1'b1;
                    st_d.cnt  = (st_q.cnt == '0) ? '0 : st_q.cnt - 1'b1;
                    upd       = (mode == TB_UPDN_DBL);
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.down = 1'b0;
                    st_d.cnt  = {{(CNT_W-1){1'b0}}, 1'b1};
                    upd       = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            if (upd) begin
                st_d.per = period;
                st_d.evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign per_act = st_q.per;
    assign running = run_ok;
    assign load    = upd || !run_ok;
    assign halted  = st_q.halt;
    assign evt     = st_q.evt;
    assign trig    = st_q.trig;

endmodule

// File: rtl/mcpwm_pair.sv
module mcpwm_pair
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             load,
    input  logic [CNT_W-1:0] duty_cfg,
    input  logic [DT_W-1:0]  dead,
    input  logic             indep,
    input  logic [1:0]       ovr_en,
    input  logic [1:0]       ovr_val,
    input  logic [1:0]       pol,
    output logic [1:0]       pins,
    output logic [1:0]       gen
);

    typedef struct packed {
        logic [CNT_W-1:0] duty;
        logic             raw;
        logic [DT_W-1:0]  dtc;
        logic [1:0]       gen;
        logic [1:0]       pin;
    } pr_st_t;

    pr_st_t st_d, st_q;
    logic   raw;
    logic   quiet;

    always_comb begin
        st_d = st_q;
        raw  = (cnt < st_q.duty);
        if (load) st_d.duty = duty_cfg;
        st_d.raw = raw;
        if (raw != st_q.raw)     st_d.dtc = dead;
        else if (st_q.dtc != '0) st_d.dtc = st_q.dtc - 1'b1;
        quiet = (st_d.dtc == '0);
        st_d.gen[SIDE_HI] = indep ? raw : (raw && quiet);
        st_d.gen[SIDE_LO] = indep ? raw : (!raw && quiet);
        for (int s = 0; s < 2; s++) begin
            st_d.pin[s] = (ovr_en[s] ? ovr_val[s] : st_d.gen[s]) ^ pol[s];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pins = st_q.pin;
    assign gen  = st_q.gen;

endmodule

// File: rtl/mcpwm_core.sv
module mcpwm_core
    import mcpwm_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int DT_W      = 4,
    parameter int NUM_PAIRS = 3,
    localparam int NPIN     = 2 * NUM_PAIRS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_run,
    input  logic [1:0]                 cfg_tbmode,
    input  logic [CNT_W-1:0]           cfg_period,
    input  logic [NUM_PAIRS*CNT_W-1:0] cfg_duty,
    input  logic [DT_W-1:0]            cfg_dead,
    input  logic [NUM_PAIRS-1:0]       cfg_indep,
    input  logic [NPIN-1:0]            cfg_pol,
    input  logic [NPIN-1:0]            ovr_en,
    input  logic [NPIN-1:0]            ovr_val,
    input  logic [CNT_W-1:0]           cfg_trig,
    output logic [NPIN-1:0]            pwm_out,
    output logic                       adc_trig,
    output logic                       tb_evt
);

    logic [CNT_W-1:0] tb_cnt;
    logic [CNT_W-1:0] tb_per;
    logic             tb_running;
    logic             tb_load;
    logic             tb_halted;
    logic [NPIN-1:0]  gen_pins;

    mcpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cfg_run),
        .mode     (cfg_tbmode),
        .period   (cfg_period),
        .trig_cmp (cfg_trig),
        .cnt      (tb_cnt),
        .per_act  (tb_per),
        .running  (tb_running),
        .load     (tb_load),
        .halted   (tb_halted),
        .evt      (tb_evt),
        .trig     (adc_trig)
    );

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        mcpwm_pair #(.CNT_W(CNT_W), .DT_W(DT_W)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (tb_cnt),
            .load     (tb_load),
            .duty_cfg (cfg_duty[i*CNT_W +: CNT_W]),
            .dead     (cfg_dead),
            .indep    (cfg_indep[i]),
            .ovr_en   (ovr_en[2*i +: 2]),
            .ovr_val  (ovr_val[2*i +: 2]),
            .pol      (cfg_pol[2*i +: 2]),
            .pins     (pwm_out[2*i +: 2]),
            .gen      (gen_pins[2*i +: 2])
        );
    end

endmodule

// File: rtl/mcpwm_core_chk.sv
module mcpwm_core_chk #(
    parameter int CNT_W     = 8,
    parameter int NUM_PAIRS = 3,
    localparam int NPIN     = 2 * NUM_PAIRS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_run,
    input logic [1:0]           cfg_tbmode,
    input logic [NUM_PAIRS-1:0] cfg_indep,
    input logic [NPIN-1:0]      cfg_pol,
    input logic [NPIN-1:0]      ovr_en,
    input logic [NPIN-1:0]      ovr_val,
    input logic [NPIN-1:0]      pwm_out,
    input logic                 adc_trig,
    input logic                 tb_evt,
    input logic [CNT_W-1:0]     tb_cnt,
    input logic [CNT_W-1:0]     tb_per,
    input logic                 tb_running,
    input logic                 tb_halted,
    input logic [NPIN-1:0]      gen_pins
);

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_running && !cfg_tbmode[1]) |-> (tb_cnt <= tb_per));

    p_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_halted && cfg_run) |=> (tb_cnt == '0));

    p_evt_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tb_evt |-> $past(tb_running));

    p_trig_running_r10: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> $past(tb_running));

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair_chk
        p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (gen_pins[2*i] && gen_pins[2*i+1]) |-> $past(cfg_indep[i]));
    end

    for (genvar j = 0; j < NPIN; j++) begin : g_pin_chk
        p_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ovr_en[j] |=> (pwm_out[j] == ($past(ovr_val[j]) ^ $past(cfg_pol[j]))));
    end

endmodule

bind mcpwm_core mcpwm_core_chk #(.CNT_W(CNT_W), .NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_run    (cfg_run),
    .cfg_tbmode (cfg_tbmode),
    .cfg_indep  (cfg_indep),
    .cfg_pol    (cfg_pol),
    .ovr_en     (ovr_en),
    .ovr_val    (ovr_val),
    .pwm_out    (pwm_out),
    .adc_trig   (adc_trig),
    .tb_evt     (tb_evt),
    .tb_cnt     (tb_cnt),
    .tb_per     (tb_per),
    .tb_running (tb_running),
    .tb_halted  (tb_halted),
    .gen_pins   (gen_pins)
);

// File: tb/mcpwm_core_bench.sv
module mcpwm_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_run = 1'b0;
    logic [1:0]    cfg_tbmode = '0;
    logic [CW-1:0] cfg_period = '0;
    logic [23:0]   cfg_duty = '0;
    logic [3:0]    cfg_dead = '0;
    logic [2:0]    cfg_indep = '0;
    logic [5:0]    cfg_pol = '0;
    logic [5:0]    ovr_en = '0;
    logic [5:0]    ovr_val = '0;
    logic [CW-1:0] cfg_trig = '0;
    logic [5:0]    pwm_out;
    logic          adc_trig;
    logic          tb_evt;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] hist [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    mcpwm_core u_mcpwm_core (
        .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_tbmode(cfg_tbmode),
        .cfg_period(cfg_period), .cfg_duty(cfg_duty), .cfg_dead(cfg_dead),
        .cfg_indep(cfg_indep), .cfg_pol(cfg_pol), .ovr_en(ovr_en), .ovr_val(ovr_val),
        .cfg_trig(cfg_trig), .pwm_out(pwm_out), .adc_trig(adc_trig), .tb_evt(tb_evt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    function automatic int cnt_of(int mode, int per, int m);
        int k;
        if (mode == 0) return m % (per + 1);
        if (mode == 1) return (m <= per) ? m : 0;
        k = m % (2 * per);
        return (k <= per) ? k : 2 * per - k;
    endfunction

    function automatic bit upd_of(int mode, int per, int m);
        int k;
        if (mode == 0) return (m % (per + 1)) == per;
        if (mode == 1) return m == per;
        k = m % (2 * per);
        return (k == 0 && m > 0) || (mode == 3 && k == per);
    endfunction

    function automatic bit up_of(int mode, int per, int m);
        int k;
        if (mode < 2) return 1'b1;
        k = m % (2 * per);
        return (m == 0) || (k >= 1 && k <= per);
    endfunction

    // one run from a stopped time base; duty switches to duty2 at cycle chg_at
    task automatic sweep(input string tag, input int mode, input int per, input logic [23:0] duty,
                         input int dead, input logic [2:0] indep, input logic [5:0] pol,
                         input int trig, input int ncyc, input int chg_at, input logic [23:0] duty2);
        int act [NP];
        bit prev_trig;
        bit prev_evt;
        cfg_run    = 1'b0;
        cfg_tbmode = 2'(mode);
        cfg_period = CW'(per);
        cfg_duty   = duty;
        cfg_dead   = 4'(dead);
        cfg_indep  = indep;
        cfg_pol    = pol;
        cfg_trig   = CW'(trig);
        ovr_en     = '0;
        repeat (20) @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            act[i]  = int'(duty[i*CW +: CW]);
            hist[i] = (act[i] > 0) ? '1 : '0;
        end
        prev_trig = 1'b0;
        prev_evt  = 1'b0;
        cfg_run = 1'b1;
        for (int m = 0; m < ncyc; m++) begin
            int c;
            logic [31:0] mask;
            logic [5:0] exp_pins;
            if (m == chg_at) cfg_duty = duty2;
            mask = (32'h1 << (dead + 1)) - 1;
            for (int i = 0; i < NP; i++) begin
                if (indep[i]) begin
                    exp_pins[2*i]   = hist[i][0];
                    exp_pins[2*i+1] = hist[i][0];
                end else begin
                    exp_pins[2*i]   = (hist[i] & mask) == mask;
                    exp_pins[2*i+1] = (hist[i] & mask) == 0;
                end
            end
            chk({tag, " pins"}, int'(pwm_out), int'(exp_pins ^ pol));
            chk("R10 adc_trig", int'(adc_trig), int'(prev_trig));
            chk("R5 tb_evt", int'(tb_evt), int'(prev_evt));
            c = cnt_of(mode, per, m);
            for (int i = 0; i < NP; i++) hist[i] = {hist[i][30:0], (c < act[i])};
            prev_trig = (c == trig) && up_of(mode, per, m) && !(mode == 1 && m > per);
            prev_evt  = upd_of(mode, per, m);
            if (prev_evt || (mode == 1 && m > per))
                for (int i = 0; i < NP; i++) act[i] = int'(cfg_duty[i*CW +: CW]);
            @(negedge clk);
        end
        cfg_run = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog R1 run hung: actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 pins in reset", int'(pwm_out), 0);
        chk("R11 trig in reset", int'(adc_trig), 0);
        chk("R11 evt in reset", int'(tb_evt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R6 R10: wrap mode, duty 0 / mid / above period, gap 2
        sweep("R1 R6", 0, 7, {8'd9, 8'd3, 8'd0}, 2, 3'b000, 6'b0, 4, 40, -1, '0);
        // R6: gap longer than a pulse swallows it
        sweep("R6 long gap", 0, 9, {8'd8, 8'd5, 8'd2}, 4, 3'b000, 6'b0, 7, 40, -1, '0);
        // R7 R8: same-waveform pairs and inversion
        sweep("R7 R8", 0, 7, {8'd7, 8'd1, 8'd5}, 3, 3'b101, 6'b100110, 0, 30, -1, '0);
        // R2: up/down with bottom reload
        sweep("R2", 2, 6, {8'd7, 8'd4, 8'd2}, 1, 3'b000, 6'b0, 3, 40, -1, '0);
        // R2 R5: up/down with double reload, no gap
        sweep("R2 R5", 3, 5, {8'd5, 8'd3, 8'd1}, 0, 3'b010, 6'b001001, 5, 30, -1, '0);
        // R3: single sweep, twice to show re-arm
        sweep("R3", 1, 6, {8'd4, 8'd3, 8'd2}, 1, 3'b000, 6'b0, 2, 20, -1, '0);
        sweep("R3 rearm", 1, 4, {8'd1, 8'd5, 8'd3}, 0, 3'b000, 6'b0, 4, 14, -1, '0);
        // R4: duty change mid-cycle held until reload
        sweep("R4", 0, 5, {8'd2, 8'd2, 8'd2}, 1, 3'b000, 6'b0, 1, 30, 8, {8'd5, 8'd1, 8'd4});
        sweep("R4 updn", 3, 4, {8'd1, 8'd2, 8'd3}, 0, 3'b000, 6'b0, 2, 30, 6, {8'd4, 8'd0, 8'd1});
        // R9: manual force over a running generator
        cfg_tbmode = 2'd0; cfg_period = 8'd7; cfg_duty = {8'd2, 8'd4, 8'd6};
        cfg_pol = 6'b000110; cfg_run = 1'b1;
        repeat (5) @(negedge clk);
        ovr_en = 6'b111111; ovr_val = 6'b101001;
        @(negedge clk);
        chk("R9 force A", int'(pwm_out), int'(6'b101001 ^ 6'b000110));
        ovr_val = 6'b010110;
        @(negedge clk);
        chk("R9 force B", int'(pwm_out), int'(6'b010110 ^ 6'b000110));
        ovr_en = '0; cfg_run = 1'b0;
        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule